// File: doc/BRIEF.md
# NOR Flash Command Decoder

This block is the device side of a word-wide parallel NOR flash bus. It watches the write cycles arriving from a host and treats them as flash commands. It also owns a small internal word array, which it reads, programs and erases on behalf of those commands. A command counts only when it arrives through an exact unlock sequence, which is a fixed data byte written to each of two fixed addresses. Any cycle that breaks the sequence sends the decoder back to idle.

After a program or erase command the block is busy for a number of clock cycles set by a parameter. While it is busy, every read returns a status word instead of array data, and bit 6 of that word flips on each read. A host that waits for the bit to stop flipping knows the operation has finished. A separate identification mode makes reads return a manufacturer code and a device code. A reset write returns the block to plain array reads.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset, every array word reads 16'hFFFF, the block is in array-read mode, and rdata is 16'h0000 until the first read.
- R2: A command sequence starts with data 8'hAA written to address 16'h5555, followed by 8'h55 written to 16'h2AAA. Only wdata[7:0] is compared. A write that does not match the expected step returns the decoder to idle, and the command that follows it has no effect.
- R3: After the unlock, 8'hA0 written to 16'h5555 arms a program. The next write replaces the word at index addr[5:0] with the old word ANDed with wdata, so bits can only be cleared.
- R4: A program keeps the block busy for PROG_CYC cycles. Exactly PROG_CYC reads issued back to back right after the data write return the status word, and the read after them returns array data.
- R5: Erase takes six writes: the unlock, 8'h80 to 16'h5555, a second unlock, then 8'h30 to any address. It sets all 8 words of the sector selected by addr[5:3] to 16'hFFFF and leaves the other words unchanged. It is busy for ERASE_CYC cycles. If the last write is not 8'h30, nothing is erased and the block does not go busy.
- R6: The status word has every bit zero except bit 6. Bit 6 is 0 on the first read of each operation and inverts on every read after that.
- R7: After the unlock, 8'h90 written to 16'h5555 enters ID mode. In ID mode, reads at index 0 return MFR_ID, reads at index 1 return DEV_ID, and reads at any other index return 16'h0000.
- R8: The unlock followed by 8'hF0 written to 16'h5555 leaves ID mode. A single write with wdata[7:0] = 8'hFF, in any state other than the armed-program state, also leaves ID mode and abandons any partly entered sequence.
- R9: Writes that arrive while the block is busy change neither the array, nor the ID mode, nor the sequence state.
- R10: The unlock and command addresses are compared over all 16 address bits. An address that differs only in bit 15 breaks the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write cycle strobe |
| rd_en | input | 1 | Read cycle strobe; rdata updates at the next edge |
| addr | input | 16 | Word address of the cycle |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, array word, ID code or status |

## Verification
A wrong sequence state does not show on any port until a later write tries to change the array. The bench therefore follows every sequence it breaks with a write that would change a known word, and reads that word back a few cycles later. A wrong busy count shows on the first read after the window: the bench reads back to back from the data write onward, so a busy period that is off by one cycle appears as a status word where array data was expected, or the reverse. A stuck or double-flipping toggle register shows up on the second status read of any operation.

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder #(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int ARRAY_AW  = 6,
  parameter int SECT_AW   = 3,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 40,
  parameter logic [15:0] MFR_ID = 16'h00C2,
  parameter logic [15:0] DEV_ID = 16'h4A17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << ARRAY_AW;
  localparam int SW    = ARRAY_AW - SECT_AW;
  localparam int CW    = $clog2(ERASE_CYC + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_CMD, S_PROG, S_ER1, S_ER2, S_ER3
  } seq_t;

  seq_t                st;
  logic                idmode;
  logic                tog;
  logic [CW-1:0]       cnt;
  logic [DW-1:0]       mem [DEPTH];
  logic [ARRAY_AW-1:0] idx;
  logic [DW-1:0]       cur_word;
  logic [DW-1:0]       id_word;
  logic [DW-1:0]       status;
  logic [7:0]          cb;
  logic                busy, hit_a, hit_b, wr_ok;

  assign idx      = addr[ARRAY_AW-1:0];
  assign cur_word = mem[idx];
  assign cb       = wdata[7:0];
  assign busy     = (cnt != '0);
  assign hit_a    = (addr == AW'(16'h5555));
  assign hit_b    = (addr == AW'(16'h2AAA));
  assign wr_ok    = wr_en && !busy;
  assign id_word  = (idx == 0) ? DW'(MFR_ID) : (idx == 1) ? DW'(DEV_ID) : '0;
  assign status   = DW'({tog, 6'b0});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      idmode <= 1'b0;
      tog    <= 1'b0;
      cnt    <= '0;
      rdata  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      if (busy) cnt <= cnt - 1'b1;
      if (rd_en) begin
        if (busy) begin
          rdata <= status;
          tog   <= ~tog;
        end else begin
          rdata <= idmode ? id_word : cur_word;
        end
      end
      if (wr_ok) begin
        if (cb == 8'hFF && st != S_PROG) begin
          st     <= S_IDLE;
          idmode <= 1'b0;
        end else begin
          case (st)
            S_IDLE: st <= (hit_a && cb == 8'hAA) ? S_UNL1 : S_IDLE;
            S_UNL1: st <= (hit_b && cb == 8'h55) ? S_CMD : S_IDLE;
            S_CMD: begin
              st <= S_IDLE;
              if (hit_a) begin
                case (cb)
                  8'hA0:   st <= S_PROG;
                  8'h80:   st <= S_ER1;
                  8'h90:   idmode <= 1'b1;
                  8'hF0:   idmode <= 1'b0;
                  default: ;
                endcase
              end
            end
            S_PROG: begin
              mem[idx] <= cur_word & wdata;
              cnt      <= CW'(PROG_CYC);
              tog      <= 1'b0;
              st       <= S_IDLE;
            end
            S_ER1: st <= (hit_a && cb == 8'hAA) ? S_ER2 : S_IDLE;
            S_ER2: st <= (hit_b && cb == 8'h55) ? S_ER3 : S_IDLE;
            S_ER3: begin
              st <= S_IDLE;
              if (cb == 8'h30) begin
                for (int i = 0; i < DEPTH; i++)
                  if (SW'(i >> SECT_AW) == idx[ARRAY_AW-1:SECT_AW]) mem[i] <= '1;
                cnt <= CW'(ERASE_CYC);
                tog <= 1'b0;
              end
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  AST_RESET_RDATA: assert property (@(posedge clk)
    !rst_n |=> rdata == '0); // R1

  AST_UNLOCK_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_UNL1 && wr_ok && !(hit_b && cb == 8'h55) |=> st == S_IDLE); // R2

  AST_PROG_AND: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_PROG && wr_ok |=> (mem[$past(idx)] | $past(cur_word)) == $past(cur_word)); // R3

  AST_PROG_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_PROG && wr_ok |=> busy); // R4

  AST_ERASE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_ER3 && wr_ok && cb == 8'h30 |=> mem[$past(idx)] == '1 && busy); // R5

  AST_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rd_en |=> (rdata & ~DW'(16'h0040)) == '0); // R6

  AST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rd_en && $past(busy && rd_en) |=> rdata[6] != $past(rdata[6])); // R6

  AST_ID_MFR: assert property (@(posedge clk) disable iff (!rst_n)
    idmode && !busy && rd_en && idx == 0 |=> rdata == DW'(MFR_ID)); // R7

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_en |=> $stable(idmode) && mem[$past(idx)] == $past(cur_word)); // R9
endmodule

// File: tb/test_nor_cmd_decoder.sv
`timescale 1ns/1ps
module test_nor_cmd_decoder;
  localparam int PROG_CYC  = 8;
  localparam int ERASE_CYC = 40;
  localparam logic [15:0] MFR = 16'h00C2;
  localparam logic [15:0] DEV = 16'h4A17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  int total = 0;
  int fails = 0;
  logic [15:0] rv;
  logic [15:0] expm [64];

  always #2.5 clk = ~clk;

  nor_cmd_decoder i_nor_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    rv = rdata;
  endtask

  task automatic unlock();
    wr(16'h5555, 16'h00AA);
    wr(16'h2AAA, 16'h0055);
  endtask

  task automatic busy_reads(input logic [15:0] a, input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      rd(a);
      check(tag, rv, (k % 2 == 1) ? 16'h0040 : 16'h0000);
    end
  endtask

  task automatic prog(input logic [15:0] a, input logic [15:0] d);
    unlock();
    wr(16'h5555, 16'h00A0);
    wr(a, d);
    expm[a[5:0]] = expm[a[5:0]] & d;
    busy_reads(a, PROG_CYC, "R4/R6 program status");
    rd(a);
    check("R4 read after program busy", rv, expm[a[5:0]]);
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 64; i++) begin
      rd(16'(i));
      check(tag, rv, expm[i]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) expm[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata after reset", rdata, 16'h0000);
    sweep("R1 erased after reset");

    // R3: program every word, then read all back
    for (int i = 0; i < 64; i++) prog(16'(i), 16'(i * 16'h0935) ^ 16'hA5C3);
    sweep("R3 program sweep");
    prog(16'd5, 16'h0F0F);
    prog(16'd6, 16'hFFFF);
    sweep("R3 second program ANDs");

    // R5: erase sector 2 (words 16..23)
    unlock();
    wr(16'h5555, 16'h0080);
    unlock();
    wr(16'd20, 16'h0030);
    for (int i = 16; i < 24; i++) expm[i] = 16'hFFFF;
    busy_reads(16'd20, ERASE_CYC, "R5/R6 erase status");
    rd(16'd20);
    check("R5 read after erase busy", rv, 16'hFFFF);
    sweep("R5 erase sweep");

    // R5: wrong final erase byte
    unlock();
    wr(16'h5555, 16'h0080);
    unlock();
    wr(16'd40, 16'h0031);
    rd(16'd40);
    check("R5 no erase on wrong byte", rv, expm[40]);

    // R2: wrong address and wrong data in second step, upper byte ignored
    wr(16'h5555, 16'h00AA);
    wr(16'h2AAB, 16'h0055);
    wr(16'h5555, 16'h00A0);
    wr(16'd3, 16'h0000);
    rd(16'd3);
    check("R2 abort on wrong address", rv, expm[3]);
    wr(16'h5555, 16'h00AA);
    wr(16'h2AAA, 16'h0054);
    wr(16'h5555, 16'h00A0);
    wr(16'd3, 16'h0000);
    rd(16'd3);
    check("R2 abort on wrong data", rv, expm[3]);
    wr(16'h5555, 16'h33AA);
    wr(16'h2AAA, 16'hC355);
    wr(16'h5555, 16'h77A0);
    wr(16'd9, 16'h00F0);
    expm[9] = expm[9] & 16'h00F0;
    busy_reads(16'd9, PROG_CYC, "R2 upper byte ignored status");
    rd(16'd9);
    check("R2 upper byte ignored", rv, expm[9]);

    // R10: bit 15 of the unlock address
    wr(16'hD555, 16'h00AA);
    wr(16'h2AAA, 16'h0055);
    wr(16'h5555, 16'h00A0);
    wr(16'd4, 16'h0000);
    rd(16'd4);
    check("R10 full address compare", rv, expm[4]);

    // R9: writes during busy are ignored
    unlock();
    wr(16'h5555, 16'h00A0);
    wr(16'd10, 16'h1234);
    expm[10] = expm[10] & 16'h1234;
    unlock();
    wr(16'h5555, 16'h00A0);
    wr(16'd11, 16'h0000);
    repeat (PROG_CYC) @(negedge clk);
    wr(16'd11, 16'h0000);
    rd(16'd11);
    check("R9 write during busy ignored", rv, expm[11]);
    rd(16'd10);
    check("R9 program before busy kept", rv, expm[10]);

    // R7: ID mode
    unlock();
    wr(16'h5555, 16'h0090);
    rd(16'd0);  check("R7 manufacturer code", rv, MFR);
    rd(16'd1);  check("R7 device code", rv, DEV);
    rd(16'd2);  check("R7 other offset", rv, 16'h0000);
    rd(16'd63); check("R7 last offset", rv, 16'h0000);
    unlock();
    wr(16'h5555, 16'h00F0);
    rd(16'd0);  check("R8 exit by unlock F0", rv, expm[0]);
    unlock();
    wr(16'h5555, 16'h0090);
    rd(16'd1);  check("R7 re-entry", rv, DEV);
    wr(16'd0, 16'h00FF);
    rd(16'd1);  check("R8 exit by FF write", rv, expm[1]);

    // R8: FF abandons a partial sequence
    unlock();
    wr(16'd12, 16'h00FF);
    wr(16'h5555, 16'h00A0);
    wr(16'd7, 16'h0000);
    rd(16'd7);
    check("R8 FF aborts sequence", rv, expm[7]);
    sweep("R9 final sweep");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule